// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bridge

This block lets a clocked host read and write an external asynchronous static RAM. The RAM is byte wide, uses 17 address bits, and has two chip selects of opposite polarity, an active-low read strobe, an active-low write strobe and a shared 8-bit data bus. The host side is a valid/ready request port. It carries an address, a write byte and a direction flag, and read results come back on a single-cycle response strobe.

Every bus phase is built from whole clock cycles. The length of each phase comes from nanosecond limits, given as picosecond parameters, divided by the clock period and rounded up. The same RTL therefore meets the RAM's access, pulse and setup windows at any clock rate. The chip-level pad ring receives a data-out value, a drive enable and a data-in value. The bridge decides when the pads drive and samples the returned byte itself.

Top module: `asram_bridge`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, `req_ready` is 1, `mem_en_lo_n` is 1, `mem_en_hi` is 0, `mem_rd_n` is 1, `mem_wr_n` is 1 and `mem_drive` is 0.
- R2: During a read, the RAM is selected (`mem_en_lo_n`=0, `mem_en_hi`=1) with `mem_rd_n`=0, `mem_wr_n`=1 and `mem_drive`=0. This holds for RD_CYC = ceil(T_RC_PS / CLK_PERIOD_PS) cycles, and the address does not change during that time.
- R3: The read byte is sampled on the last clock of the access phase. `rsp_valid` is then high for exactly one cycle, RD_CYC cycles after the accepting edge, and `rsp_rdata` equals the byte most recently written to that address.
- R4: A write has three phases. First comes one setup cycle with the RAM selected and `mem_wr_n`=1. Next, `mem_wr_n`=0 for WR_CYC cycles, where WR_CYC = max(ceil(T_WP), ceil(T_DW), ceil(T_AW)-1) in clock periods. Last comes one hold cycle with `mem_wr_n`=1, the RAM still selected and the data still driven.
- R5: `mem_rd_n` stays 1 for the whole write. `mem_drive` is 1 only during write phases and never while `mem_rd_n` is 0.
- R6: While `mem_wr_n` is 0, neither `mem_addr` nor `mem_wdata` changes. The address changes only at acceptance, when `mem_wr_n` is 1.
- R7: A write that follows a read waits TURN_CYC (at least 1) extra cycles with all strobes idle. Its `mem_wr_n` falls two cycles after acceptance, against one cycle for a write that does not follow a read.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the accepting edge until the transaction ends, and writes produce no response.
- R9: With RDATA_HOLD=1, `rsp_rdata` keeps the last read byte after `rsp_valid` falls, including across later writes. With RDATA_HOLD=0, it reads 0 outside the valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_en_lo_n | output | 1 | Active-low chip select |
| mem_en_hi | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_wdata | output | DATA_W | Data toward the pad drivers |
| mem_drive | output | 1 | Pad drive enable for the data bus |
| mem_rdata | input | DATA_W | Data from the pad receivers |

## Verification
The bench builds the bridge with its default parameters: a 5000 ps clock period, 70/50/70/30 ns access, pulse, address-to-end and data-setup limits, and RDATA_HOLD=1. These values give a 14-cycle read phase and a 13-cycle write pulse, so an off-by-one in either counter moves the sampling edge or the strobe edge onto a checked boundary. The bench's RAM model returns a wrong byte until 14 cycles of stable read conditions have passed. It also measures each write's pulse, address-valid and data-setup windows against their nanosecond minimums. The turnaround and hold-register paths are reached by mixing random read/write sequences over a small hot address set with directed back-to-back read-then-write cases.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_TURN  = 3'd1,
      ST_RD    = 3'd2,
      ST_WSET  = 3'd3,
      ST_WPUL  = 3'd4,
      ST_WHOLD = 3'd5
   } asram_st_e;

   typedef struct packed {
      logic sel;    // both chip selects active
      logic rd;     // output enable active
      logic wr;     // write strobe active
      logic drv;    // pads drive the data bus
   } pin_set_t;

   localparam pin_set_t PINS_IDLE = '{sel: 1'b0, rd: 1'b0, wr: 1'b0, drv: 1'b0};

   // Cycles needed to cover t_ps, rounded up, never below one.
   function automatic int unsigned cyc_ceil(input int unsigned t_ps,
                                            input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_set_t pins_for(input asram_st_e st);
      pin_set_t p;
      p = PINS_IDLE;
      case (st)
         ST_RD:    begin p.sel = 1'b1; p.rd = 1'b1; end
         ST_WSET:  begin p.sel = 1'b1; p.drv = 1'b1; end
         ST_WPUL:  begin p.sel = 1'b1; p.wr = 1'b1; p.drv = 1'b1; end
         ST_WHOLD: begin p.sel = 1'b1; p.drv = 1'b1; end
         default:  p = PINS_IDLE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int unsigned RD_CYC   = 14,
   parameter int unsigned WR_CYC   = 13,
   parameter int unsigned TURN_CYC = 1,
   parameter int unsigned CNT_W    = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_write,
   output logic      req_ready,
   output logic      accept,
   output logic      capture,
   output asram_st_e state_d
);
   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

   asram_st_e        state_q;
   logic             last_rd_q, last_rd_d;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             done;

   asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (done)
   );

   always_comb begin
      state_d   = state_q;
      last_rd_d = last_rd_q;
      ld        = 1'b0;
      ld_val    = '0;
      case (state_q)
         ST_IDLE: if (req_valid) begin
            if (req_write) begin
               if (last_rd_q) begin
                  state_d = ST_TURN;
                  ld      = 1'b1;
                  ld_val  = TURN_LD;
               end else begin
                  state_d = ST_WSET;
               end
            end else begin
               state_d = ST_RD;
               ld      = 1'b1;
               ld_val  = RD_LD;
            end
         end
         ST_TURN: if (done) state_d = ST_WSET;
         ST_RD: if (done) begin
            state_d   = ST_IDLE;
            last_rd_d = 1'b1;
         end
         ST_WSET: begin
            state_d = ST_WPUL;
            ld      = 1'b1;
            ld_val  = WR_LD;
         end
         ST_WPUL: if (done) state_d = ST_WHOLD;
         ST_WHOLD: begin
            state_d   = ST_IDLE;
            last_rd_d = 1'b0;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         last_rd_q <= last_rd_d;
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign capture   = (state_q == ST_RD) && done;
endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  asram_st_e state_d,
   output logic      mem_en_lo_n,
   output logic      mem_en_hi,
   output logic      mem_rd_n,
   output logic      mem_wr_n,
   output logic      mem_drive
);
   pin_set_t pins_q;

   // Strobes come straight from flops so the pads see no decode glitches.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= PINS_IDLE;
      else        pins_q <= pins_for(state_d);
   end

   assign mem_en_lo_n = ~pins_q.sel;
   assign mem_en_hi   =  pins_q.sel;
   assign mem_rd_n    = ~pins_q.rd;
   assign mem_wr_n    = ~pins_q.wr;
   assign mem_drive   =  pins_q.drv;
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter bit          RDATA_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;
   logic              vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= capture;
         if (capture) rd_q <= mem_rdata;
      end
   end

   generate
      if (RDATA_HOLD) begin : g_hold
         assign rsp_rdata = rd_q;
      end else begin : g_mask
         assign rsp_rdata = vld_q ? rd_q : '0;
      end
   endgenerate

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign rsp_valid = vld_q;
endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned T_RC_PS       = 70000,
   parameter int unsigned T_WP_PS       = 50000,
   parameter int unsigned T_AW_PS       = 70000,
   parameter int unsigned T_DW_PS       = 30000,
   parameter int unsigned T_TURN_PS     = 5000,
   parameter bit          RDATA_HOLD    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_en_lo_n,
   output logic              mem_en_hi,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_drive,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int unsigned RD_CYC   = cyc_ceil(T_RC_PS, CLK_PERIOD_PS);
   localparam int unsigned AW_REST  = cyc_ceil(T_AW_PS, CLK_PERIOD_PS) - 1;
   localparam int unsigned WR_CYC   = max2(max2(cyc_ceil(T_WP_PS, CLK_PERIOD_PS),
                                                cyc_ceil(T_DW_PS, CLK_PERIOD_PS)),
                                           AW_REST);
   localparam int unsigned TURN_CYC = cyc_ceil(T_TURN_PS, CLK_PERIOD_PS);
   localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WR_CYC), TURN_CYC);
   localparam int unsigned CNT_W    = max2(1, $clog2(MAX_CYC));

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_bridge: address and data widths must be at least 1");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("asram_bridge: clock period must be nonzero");
      end
      if (MAX_CYC > 65535) begin : g_bad_phase
         $error("asram_bridge: phase length exceeds 16-bit checker range");
      end
   endgenerate

   asram_st_e state_d;
   logic      accept;
   logic      capture;

   asram_fsm #(
      .RD_CYC   (RD_CYC),
      .WR_CYC   (WR_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture),
      .state_d   (state_d)
   );

   asram_pins u_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_d     (state_d),
      .mem_en_lo_n (mem_en_lo_n),
      .mem_en_hi   (mem_en_hi),
      .mem_rd_n    (mem_rd_n),
      .mem_wr_n    (mem_wr_n),
      .mem_drive   (mem_drive)
   );

   asram_datapath #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .RDATA_HOLD (RDATA_HOLD)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WR_CYC = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_en_lo_n,
   input logic              mem_en_hi,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_drive
);
   localparam logic [15:0] WR_CYC_W = 16'(WR_CYC);

   logic [15:0] lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lo_cnt <= '0;
      else if (!mem_wr_n) lo_cnt <= lo_cnt + 16'd1;
      else                lo_cnt <= '0;
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_en_lo_n && !mem_en_hi && mem_rd_n && mem_wr_n && !mem_drive)); // R1
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_drive && !mem_rd_n)); // R5
   AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (mem_rd_n && mem_drive)); // R5
   AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (!mem_en_lo_n && mem_en_hi)); // R4
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (lo_cnt == WR_CYC_W)); // R4
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n && !$past(mem_wr_n)) |-> $stable(mem_addr)); // R6
   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n && !$past(mem_wr_n)) |-> $stable(mem_wdata)); // R6
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_drive) |-> $past(mem_rd_n)); // R7
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3
   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8
endmodule

bind asram_bridge asram_bridge_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WR_CYC (WR_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .mem_addr    (mem_addr),
   .mem_en_lo_n (mem_en_lo_n),
   .mem_en_hi   (mem_en_hi),
   .mem_rd_n    (mem_rd_n),
   .mem_wr_n    (mem_wr_n),
   .mem_wdata   (mem_wdata),
   .mem_drive   (mem_drive)
);

// File: tb/asram_bridge_tb_top.sv
`timescale 1ns/1ps
module asram_bridge_tb_top;
   localparam int AW        = 17;
   localparam int DW        = 8;
   localparam int EXP_RD    = 14;  // 70 ns / 5 ns
   localparam int EXP_WLO   = 13;  // max(10, 6, 14-1)
   localparam int MIN_WP    = 10;  // 50 ns
   localparam int MIN_DS    = 6;   // 30 ns
   localparam int MIN_AV    = 14;  // 70 ns
   localparam int T_ACC     = 14;  // model access cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_en_lo_n, mem_en_hi, mem_rd_n, mem_wr_n, mem_drive;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0, fails = 0, rsp_cnt = 0, rd_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   asram_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_en_lo_n(mem_en_lo_n), .mem_en_hi(mem_en_hi), .mem_rd_n(mem_rd_n),
      .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
      .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] init_byte(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
   endfunction

   // ---------------- RAM model with timing checks ----------------
   logic [DW-1:0] mdl_mem [int];
   logic [DW-1:0] exp_mem [int];
   logic [DW-1:0] exp_q [$];

   function automatic logic [DW-1:0] mdl_val(input logic [AW-1:0] a);
      return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : init_byte(a);
   endfunction
   function automatic logic [DW-1:0] exp_val(input logic [AW-1:0] a);
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(a);
   endfunction

   int acc = 0, a_cnt = 0, d_cnt = 0, w_cnt = 0;
   int p_a_cnt = 0, p_d_cnt = 0;
   bit p_rdc = 0, p_welo = 0, p_drv = 0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_wd = '0;

   always @(negedge clk) begin
      bit sel, rdc, welo;
      sel  = !mem_en_lo_n && mem_en_hi;
      rdc  = sel && !mem_rd_n && mem_wr_n;
      welo = sel && !mem_wr_n;
      if (rdc) acc = (p_rdc && mem_addr == p_addr) ? acc + 1 : 1;
      else     acc = 0;
      mem_rdata <= (rdc && acc >= T_ACC) ? mdl_val(mem_addr) : ~mdl_val(mem_addr);
      a_cnt = (mem_addr == p_addr) ? a_cnt + 1 : 1;
      if (mem_drive) d_cnt = (p_drv && mem_wdata == p_wd) ? d_cnt + 1 : 1;
      else           d_cnt = 0;
      if (welo) w_cnt++;
      if (p_welo && !welo) begin
         chk(w_cnt >= MIN_WP, "R4 write pulse too short", w_cnt, MIN_WP);
         chk(p_d_cnt >= MIN_DS, "R4 data setup before write end", p_d_cnt, MIN_DS);
         chk(p_a_cnt >= MIN_AV, "R6 address valid to write end", p_a_cnt, MIN_AV);
         chk(sel && mem_drive && mem_wdata == p_wd, "R4 hold cycle after write",
             {sel, mem_drive}, 2'b11);
         mdl_mem[int'(p_addr)] = p_wd;
         w_cnt = 0;
      end
      p_a_cnt = a_cnt; p_d_cnt = d_cnt;
      p_rdc = rdc; p_welo = welo; p_drv = mem_drive;
      p_addr = mem_addr; p_wd = mem_wdata;
   end

   // ---------------- response monitor ----------------
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         rsp_cnt++;
         if (exp_q.size() == 0) chk(1'b0, "R8 response without read", 1, 0);
         else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
         end
      end
   end

   task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (w) exp_mem[int'(a)] = d;
      else begin exp_q.push_back(exp_val(a)); rd_cnt++; end
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      logic [DW-1:0] held;
      logic [31:0] r;
      int unsigned seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && mem_en_lo_n && !mem_en_hi && mem_rd_n && mem_wr_n && !mem_drive && !rsp_valid,
          "R1 idle pins after reset", {req_ready, mem_en_lo_n, mem_en_hi, mem_rd_n, mem_wr_n, mem_drive}, 6'b110110);

      // R4/R7 write with no read before: strobe falls 1 cycle after acceptance
      do_req(1'b1, 17'h00A5A, 8'h3C);
      chk(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
      n = 0;
      while (mem_wr_n) begin @(negedge clk); n++; end
      chk(n == 1, "R7 write latency without prior read", n, 1);
      chk(mem_rd_n && mem_drive, "R5 output enable off and bus driven during write", {mem_rd_n, mem_drive}, 2'b11);
      n = 0;
      while (!mem_wr_n) begin n++; @(negedge clk); end
      chk(n == EXP_WLO, "R4 write strobe length", n, EXP_WLO);
      wait_idle();
      chk(rsp_cnt == 0, "R8 no response for writes", rsp_cnt, 0);

      // R2/R3 read back with latency
      do_req(1'b0, 17'h00A5A, 8'h00);
      chk(!mem_en_lo_n && mem_en_hi && !mem_rd_n && mem_wr_n && !mem_drive,
          "R2 read strobe pins", {mem_en_lo_n, mem_en_hi, mem_rd_n, mem_wr_n, mem_drive}, 5'b01010);
      n = 0;
      while (!rsp_valid) begin @(negedge clk); n++; end
      chk(n == EXP_RD, "R3 read latency", n, EXP_RD);
      chk(rsp_rdata == 8'h3C, "R3 read of written byte", rsp_rdata, 8'h3C);
      held = rsp_rdata;

      // R7 write directly after read: one extra turnaround cycle
      do_req(1'b1, 17'h1FFFF, 8'hC3);
      n = 0;
      while (mem_wr_n) begin @(negedge clk); n++; end
      chk(n == 2, "R7 write latency after read", n, 2);
      wait_idle();
      chk(rsp_rdata == held, "R9 read data held across write", rsp_rdata, held);

      // boundary addresses
      do_req(1'b1, 17'h00000, 8'h81);
      do_req(1'b0, 17'h00000, 8'h00);
      do_req(1'b0, 17'h1FFFF, 8'h00);
      do_req(1'b0, 17'h10000, 8'h00);   // never written: initial pattern
      wait_idle();

      // constrained random mix
      seed = 32'h5EED_0A17;
      void'($urandom(seed));
      for (int i = 0; i < 300; i++) begin
         logic [AW-1:0] a;
         r = $urandom();
         a = r[2] ? (17'h1F000 | 17'(r[6:3])) : 17'(r[31:15]);
         do_req(r[0], a, r[14:7]);
         for (int g = 0; g < int'(r[9:8]) % 3; g++) @(negedge clk);
      end
      wait_idle();
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && rsp_cnt == rd_cnt, "R8 one response per read", rsp_cnt, rd_cnt);
      chk(mem_en_lo_n && !mem_en_hi && mem_wr_n && mem_rd_n && !mem_drive,
          "R1 idle pins after traffic", {mem_en_lo_n, mem_en_hi, mem_wr_n, mem_rd_n, mem_drive}, 5'b10110);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule